// File: doc/BRIEF.md
# Variable-Size Erase Range Splitter

This block takes one erase request, a start offset and a length across a flash array, and turns it into a series of single-block erase commands. The array is described by a static table of up to four erase regions. Each region has a start offset, a block size that is a power of two, and a block count. The block finds the region that holds each end of the request and rejects the request if either end is off that region's block grid. An accepted request is then walked block by block. Each command carries a chip number, an address inside the chip and the block size of the region the walk is in.

The walk steps into the next region when the offset reaches the end of the current one. When the in-chip address passes the chip size, it wraps to zero on the next chip. The walk ends early when the chip number reaches the configured chip count. A consumer accepts commands with a valid/ready handshake and returns an error code in the handshake cycle. A nonzero code stops the walk at once and is passed back in the response. The region table, chip shift and chip count are static inputs.

Top module: `erase_splitter`

## Requirements
- R1: After reset `reqReady` is 1, and both `cmdValid` and `rspValid` are 0.
- R2: The start region is the last region, among the first `cfgRegCount`, whose offset is less than or equal to the start offset. If the start offset is not a multiple of that region's block size, the request is rejected. A rejected request pulses `rspValid` with `rspMisalign`=1 and `rspErr`=0 two cycles after the request is accepted, and emits no command.
- R3: The end region is found the same way for the address start plus length. If that address is not a multiple of the end region's block size, the request is rejected as in R2.
- R4: For each command, `cmdSize` is 2 to the power of the current region's size exponent. The first command has `cmdChip` = start >> `cfgChipShift` and `cmdAddr` equal to the low `cfgChipShift` bits of the start. Each accepted command advances the address and offset by `cmdSize` and reduces the remaining length by `cmdSize`.
- R5: After a step, if the offset equals region offset + (block count << size exponent) and a further region exists, the walk moves to the next region.
- R6: If a step carries the in-chip address to 2^`cfgChipShift`, the address becomes 0 and the chip number increments. If the chip number then reaches `cfgChipCount`, the walk ends with a good response.
- R7: A nonzero `cmdErr` in the handshake cycle stops the walk. No further command is issued, and the next cycle pulses `rspValid` with `rspErr` equal to that code and `rspMisalign`=0. This holds even when that command would have been the last one.
- R8: An aligned request of zero length emits no command and pulses `rspValid` with `rspMisalign`=0 and `rspErr`=0 two cycles after acceptance.
- R9: While `cmdValid` is high and `cmdReady` is low, the command fields hold steady. `reqReady` is low from acceptance until the response.
- R10: Once the remaining length reaches zero, the cycle after the last handshake pulses `rspValid` with `rspMisalign`=0 and `rspErr`=0. Commands follow one per cycle while `cmdReady` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Erase request present |
| reqReady | output | 1 | Block idle and able to take a request |
| reqOfs | input | ADDR_W | Start offset of the range |
| reqLen | input | ADDR_W | Length of the range |
| rspValid | output | 1 | One-cycle completion pulse |
| rspMisalign | output | 1 | Request rejected for alignment |
| rspErr | output | ERR_W | Error code returned by the consumer, 0 if none |
| cmdValid | output | 1 | Block erase command present |
| cmdReady | input | 1 | Consumer takes the command |
| cmdChip | output | CHIP_W | Chip number |
| cmdAddr | output | ADDR_W | Address inside the chip |
| cmdSize | output | ADDR_W | Block size in bytes |
| cmdErr | input | ERR_W | Consumer error code, sampled in the handshake cycle |
| cfgRegCount | input | IDX_W+1 | Number of regions in use (1 to N_REG) |
| cfgRegOfs | input | N_REG*ADDR_W | Region start offsets, region 0 in the low bits |
| cfgRegLog2 | input | N_REG*LOG_W | Region block size exponents |
| cfgRegBlocks | input | N_REG*BLK_W | Region block counts |
| cfgChipShift | input | LOG_W | Base-2 log of the chip size |
| cfgChipCount | input | CHIP_W+1 | Number of chips |

## Verification
Two events can land on the same step. A region end can coincide with a chip boundary, so the region advance and the address wrap update together. A consumer error can also arrive on the command that already exhausts the length. The bench places a region end exactly on a 64 KiB chip boundary, so both updates take effect on one step. A scoreboard, built from its own model of the walk, then expects the following command to carry the new chip, address zero and the next region's size. The bench also returns an error on the final command of a range, and on the first, and checks that the response carries that code and that no command follows.

// File: rtl/erase_split_pkg.sv
package erase_split_pkg;
  typedef struct packed {
    logic load;     // capture a new request
    logic start;    // set up the walk from the start offset
    logic step;     // advance after a good handshake
    logic failMis;  // record an alignment reject
    logic failErr;  // record the consumer error code
  } strobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_CHECK, ST_ISSUE, ST_RESP} state_t;
endpackage

// File: rtl/erase_split_ctrl.sv
module erase_split_ctrl
  import erase_split_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    cmdReady,
  input  logic    misalign,
  input  logic    zeroLen,
  input  logic    errHit,
  input  logic    lastStep,
  output logic    reqReady,
  output logic    cmdValid,
  output logic    rspValid,
  output strobe_t strobe
);
  state_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        strobe.load = 1'b1;
        stateNext   = ST_CHECK;
      end
      ST_CHECK: begin
        if (misalign) begin
          strobe.failMis = 1'b1;
          stateNext      = ST_RESP;
        end else if (zeroLen) begin
          stateNext = ST_RESP;
        end else begin
          strobe.start = 1'b1;
          stateNext    = ST_ISSUE;
        end
      end
      ST_ISSUE: if (cmdReady) begin
        if (errHit) begin
          strobe.failErr = 1'b1;
          stateNext      = ST_RESP;
        end else begin
          strobe.step = 1'b1;
          if (lastStep) stateNext = ST_RESP;
        end
      end
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign cmdValid = (state == ST_ISSUE);
  assign rspValid = (state == ST_RESP);
endmodule

// File: rtl/erase_split_dp.sv
module erase_split_dp
  import erase_split_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_REG  = 4,
  parameter int LOG_W  = 5,
  parameter int BLK_W  = 16,
  parameter int CHIP_W = 4,
  parameter int ERR_W  = 4,
  localparam int IDX_W = (N_REG > 1) ? $clog2(N_REG) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 strobe,
  input  logic [ADDR_W-1:0]       reqOfs,
  input  logic [ADDR_W-1:0]       reqLen,
  input  logic [ERR_W-1:0]        cmdErr,
  input  logic [IDX_W:0]          cfgRegCount,
  input  logic [N_REG*ADDR_W-1:0] cfgRegOfs,
  input  logic [N_REG*LOG_W-1:0]  cfgRegLog2,
  input  logic [N_REG*BLK_W-1:0]  cfgRegBlocks,
  input  logic [LOG_W-1:0]        cfgChipShift,
  input  logic [CHIP_W:0]         cfgChipCount,
  output logic                    misalign,
  output logic                    zeroLen,
  output logic                    errHit,
  output logic                    lastStep,
  output logic [CHIP_W-1:0]       cmdChip,
  output logic [ADDR_W-1:0]       cmdAddr,
  output logic [ADDR_W-1:0]       cmdSize,
  output logic                    rspMisalign,
  output logic [ERR_W-1:0]        rspErr
);
  logic [ADDR_W-1:0] regOfs  [N_REG];
  logic [ADDR_W-1:0] regSize [N_REG];
  logic [ADDR_W-1:0] regEnd  [N_REG];

  for (genvar g = 0; g < N_REG; g++) begin : g_region
    assign regOfs[g]  = cfgRegOfs[g*ADDR_W +: ADDR_W];
    assign regSize[g] = ADDR_W'(1) << cfgRegLog2[g*LOG_W +: LOG_W];
    assign regEnd[g]  = regOfs[g] +
                        (ADDR_W'(cfgRegBlocks[g*BLK_W +: BLK_W]) << cfgRegLog2[g*LOG_W +: LOG_W]);
  end

  logic [ADDR_W-1:0] ofsQ, lenQ, addrQ;
  logic [CHIP_W-1:0] chipQ;
  logic [IDX_W-1:0]  idxQ;
  logic              misQ;
  logic [ERR_W-1:0]  errQ;

  logic [ADDR_W-1:0] endAddr, chipMask, curSize, addrNext, ofsNext;
  logic [IDX_W-1:0]  startIdx, endIdx;
  logic              wrap, chipsDone, advance;

  assign endAddr = ofsQ + lenQ;

  // last region, among those in use, whose offset does not exceed the address
  always_comb begin
    startIdx = '0;
    endIdx   = '0;
    for (int i = 0; i < N_REG; i++) begin
      if ((IDX_W+1)'(i) < cfgRegCount) begin
        if (regOfs[i] <= ofsQ)    startIdx = IDX_W'(i);
        if (regOfs[i] <= endAddr) endIdx   = IDX_W'(i);
      end
    end
  end

  assign misalign = ((ofsQ & (regSize[startIdx] - 1'b1)) != '0) ||
                    ((endAddr & (regSize[endIdx] - 1'b1)) != '0);
  assign zeroLen  = (lenQ == '0);

  assign chipMask  = (ADDR_W'(1) << cfgChipShift) - 1'b1;
  assign curSize   = regSize[idxQ];
  assign addrNext  = addrQ + curSize;
  assign ofsNext   = ofsQ + curSize;
  assign wrap      = (addrNext >> cfgChipShift) != '0;
  assign chipsDone = wrap && (({1'b0, chipQ} + 1'b1) >= cfgChipCount);
  assign lastStep  = (lenQ <= curSize) || chipsDone;
  assign advance   = (ofsNext == regEnd[idxQ]) && ((IDX_W+1)'(idxQ) + 1'b1 < cfgRegCount);
  assign errHit    = (cmdErr != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ofsQ  <= '0;
      lenQ  <= '0;
      addrQ <= '0;
      chipQ <= '0;
      idxQ  <= '0;
      misQ  <= 1'b0;
      errQ  <= '0;
    end else begin
      if (strobe.load) begin
        ofsQ <= reqOfs;
        lenQ <= reqLen;
        misQ <= 1'b0;
        errQ <= '0;
      end
      if (strobe.start) begin
        idxQ  <= startIdx;
        chipQ <= CHIP_W'(ofsQ >> cfgChipShift);
        addrQ <= ofsQ & chipMask;
      end
      if (strobe.step) begin
        ofsQ <= ofsNext;
        lenQ <= lastStep ? '0 : lenQ - curSize;
        if (advance) idxQ <= idxQ + 1'b1;
        if (wrap) begin
          addrQ <= '0;
          chipQ <= chipQ + 1'b1;
        end else begin
          addrQ <= addrNext;
        end
      end
      if (strobe.failMis) misQ <= 1'b1;
      if (strobe.failErr) errQ <= cmdErr;
    end
  end

  assign cmdChip     = chipQ;
  assign cmdAddr     = addrQ;
  assign cmdSize     = curSize;
  assign rspMisalign = misQ;
  assign rspErr      = errQ;
endmodule

// File: rtl/erase_splitter.sv
module erase_splitter
  import erase_split_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int N_REG  = 4,
  parameter int LOG_W  = 5,
  parameter int BLK_W  = 16,
  parameter int CHIP_W = 4,
  parameter int ERR_W  = 4,
  localparam int IDX_W = (N_REG > 1) ? $clog2(N_REG) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [ADDR_W-1:0]       reqOfs,
  input  logic [ADDR_W-1:0]       reqLen,
  output logic                    rspValid,
  output logic                    rspMisalign,
  output logic [ERR_W-1:0]        rspErr,
  output logic                    cmdValid,
  input  logic                    cmdReady,
  output logic [CHIP_W-1:0]       cmdChip,
  output logic [ADDR_W-1:0]       cmdAddr,
  output logic [ADDR_W-1:0]       cmdSize,
  input  logic [ERR_W-1:0]        cmdErr,
  input  logic [IDX_W:0]          cfgRegCount,
  input  logic [N_REG*ADDR_W-1:0] cfgRegOfs,
  input  logic [N_REG*LOG_W-1:0]  cfgRegLog2,
  input  logic [N_REG*BLK_W-1:0]  cfgRegBlocks,
  input  logic [LOG_W-1:0]        cfgChipShift,
  input  logic [CHIP_W:0]         cfgChipCount
);
  strobe_t strobe;
  logic    misalign, zeroLen, errHit, lastStep;

  erase_split_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .cmdReady (cmdReady),
    .misalign (misalign),
    .zeroLen  (zeroLen),
    .errHit   (errHit),
    .lastStep (lastStep),
    .reqReady (reqReady),
    .cmdValid (cmdValid),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  erase_split_dp #(
    .ADDR_W (ADDR_W), .N_REG (N_REG), .LOG_W (LOG_W),
    .BLK_W  (BLK_W),  .CHIP_W(CHIP_W), .ERR_W (ERR_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .reqOfs       (reqOfs),
    .reqLen       (reqLen),
    .cmdErr       (cmdErr),
    .cfgRegCount  (cfgRegCount),
    .cfgRegOfs    (cfgRegOfs),
    .cfgRegLog2   (cfgRegLog2),
    .cfgRegBlocks (cfgRegBlocks),
    .cfgChipShift (cfgChipShift),
    .cfgChipCount (cfgChipCount),
    .misalign     (misalign),
    .zeroLen      (zeroLen),
    .errHit       (errHit),
    .lastStep     (lastStep),
    .cmdChip      (cmdChip),
    .cmdAddr      (cmdAddr),
    .cmdSize      (cmdSize),
    .rspMisalign  (rspMisalign),
    .rspErr       (rspErr)
  );
endmodule

// File: rtl/erase_split_chk.sv
module erase_split_chk #(
  parameter int ADDR_W = 32,
  parameter int CHIP_W = 4,
  parameter int ERR_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic              rspMisalign,
  input logic [ERR_W-1:0]  rspErr,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [CHIP_W-1:0] cmdChip,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [ADDR_W-1:0] cmdSize,
  input logic [ERR_W-1:0]  cmdErr,
  input logic [CHIP_W:0]   cfgChipCount
);
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && !cmdReady |=> cmdValid && $stable(cmdAddr) && $stable(cmdChip) && $stable(cmdSize)); // R9
  AST_BUSY_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !reqReady); // R9
  AST_SIZE_POW2: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> $countones(cmdSize) == 1); // R4
  AST_ADDR_ON_GRID: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (cmdAddr & (cmdSize - 1'b1)) == '0); // R4
  AST_CHIP_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> ({1'b0, cmdChip} < cfgChipCount)); // R6
  AST_ERR_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid && cmdReady && (cmdErr != '0) |=> rspValid && !cmdValid && !rspMisalign && (rspErr == $past(cmdErr))); // R7
  AST_MIS_NO_ERR: assert property (@(posedge clk) disable iff (!rstN)
    rspValid && rspMisalign |-> rspErr == '0); // R2
endmodule

bind erase_splitter erase_split_chk #(
  .ADDR_W (ADDR_W), .CHIP_W (CHIP_W), .ERR_W (ERR_W)
) u_chk (.*);

// File: tb/erase_splitter_tb.sv
module erase_splitter_tb;
  localparam int ADDR_W = 32, N_REG = 4, LOG_W = 5, BLK_W = 16, CHIP_W = 4, ERR_W = 4;

  logic clk = 1'b0, rstN = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic reqValid = 0, reqReady;
  logic [ADDR_W-1:0] reqOfs = 0, reqLen = 0;
  logic rspValid, rspMisalign;
  logic [ERR_W-1:0] rspErr;
  logic cmdValid, cmdReady = 0;
  logic [CHIP_W-1:0] cmdChip;
  logic [ADDR_W-1:0] cmdAddr, cmdSize;
  logic [ERR_W-1:0] cmdErr = 0;
  logic [2:0] cfgRegCount = 3'd4;
  logic [N_REG*ADDR_W-1:0] cfgRegOfs;
  logic [N_REG*LOG_W-1:0] cfgRegLog2;
  logic [N_REG*BLK_W-1:0] cfgRegBlocks;
  logic [LOG_W-1:0] cfgChipShift = 5'd16;
  logic [CHIP_W:0] cfgChipCount = 5'd6;

  // region table: 4K x4 @0, 16K x3 @0x4000, 64K x2 @0x10000, 32K x8 @0x30000
  int unsigned tOfs [4] = '{32'h0, 32'h4000, 32'h10000, 32'h30000};
  int unsigned tLog [4] = '{12, 14, 16, 15};
  int unsigned tBlk [4] = '{4, 3, 2, 8};

  always_comb begin
    for (int i = 0; i < N_REG; i++) begin
      cfgRegOfs[i*ADDR_W +: ADDR_W]  = tOfs[i];
      cfgRegLog2[i*LOG_W +: LOG_W]   = LOG_W'(tLog[i]);
      cfgRegBlocks[i*BLK_W +: BLK_W] = BLK_W'(tBlk[i]);
    end
  end

  erase_splitter u_dut (.*);

  typedef struct packed {logic [CHIP_W-1:0] chip; logic [31:0] addr; logic [31:0] size;} cmd_t;
  cmd_t expQ[$];
  logic expMis;
  logic [ERR_W-1:0] expErr;
  int errIdx = -1;
  logic [ERR_W-1:0] errCode = 0;
  int cmdIdx = 0;
  int checks = 0, errors = 0;
  int cyc = 0, startCyc = 0, expLat = -1;
  bit rspSeen = 0, stallMode = 0, finished = 0;
  string curReq = "";

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s (%s): actual %0h expected %0h", req, what, curReq, act, exp);
    end
  endtask

  function automatic int lookup(input longint unsigned x);
    int r = 0;
    for (int i = 0; i < int'(cfgRegCount); i++) if (longint'(tOfs[i]) <= x) r = i;
    return r;
  endfunction

  // independent model of the walk, fills the scoreboard
  task automatic model(input longint unsigned ofs, input longint unsigned len);
    int s = lookup(ofs), e = lookup(ofs + len), idx;
    longint unsigned chipSz = 64'd1 << cfgChipShift, addr, sz;
    int chip, n = 0;
    bit last;
    expMis = 0; expErr = 0;
    if ((ofs % (64'd1 << tLog[s])) != 0 || ((ofs + len) % (64'd1 << tLog[e])) != 0) begin
      expMis = 1; expLat = 2; return;
    end
    if (len == 0) begin expLat = 2; return; end
    expLat = -1;
    idx = s; chip = int'(ofs / chipSz); addr = ofs % chipSz;
    forever begin
      sz = 64'd1 << tLog[idx];
      expQ.push_back('{chip: CHIP_W'(chip), addr: 32'(addr), size: 32'(sz)});
      if (n == errIdx) begin expErr = errCode; break; end
      n++;
      last = (len <= sz);
      ofs += sz; len -= sz;
      if (ofs == tOfs[idx] + (longint'(tBlk[idx]) << tLog[idx]) && idx + 1 < int'(cfgRegCount)) idx++;
      addr += sz;
      if (addr >= chipSz) begin
        addr = 0; chip++;
        if (chip >= int'(cfgChipCount)) last = 1;
      end
      if (last) break;
    end
  endtask

  task automatic run(input string name, input logic [31:0] ofs, input logic [31:0] len,
                     input int eIdx, input logic [ERR_W-1:0] eCode, input bit stall);
    curReq = name; errIdx = eIdx; errCode = eCode; stallMode = stall; cmdIdx = 0;
    model(ofs, len);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqOfs = ofs; reqLen = len; reqValid = 1; startCyc = cyc;
    @(negedge clk);
    reqValid = 0;
    while (!rspSeen) @(negedge clk);
    rspSeen = 0;
    chk(expQ.size() == 0, "R10", "commands missing at response", expQ.size(), 0);
    expQ.delete();
  endtask

  // monitor: drives the consumer side and compares against the scoreboard
  initial begin : monitor
    cmd_t e, held;
    bit wasHeld = 0;
    forever begin
      @(negedge clk);
      if (!rstN) continue;
      if (wasHeld && cmdValid)
        chk(cmdAddr == held.addr && cmdChip == held.chip && cmdSize == held.size,
            "R9", "command changed while stalled", cmdAddr, held.addr);
      cmdReady = stallMode ? (($urandom % 3) != 0) : 1'b1;
      cmdErr = 0;
      wasHeld = 0;
      if (cmdValid) chk(!reqReady, "R9", "reqReady while busy", reqReady, 0);
      if (cmdValid && !cmdReady) begin
        wasHeld = 1; held = '{chip: cmdChip, addr: cmdAddr, size: cmdSize};
      end
      if (cmdValid && cmdReady) begin
        if (expQ.size() == 0) chk(0, "R10", "unexpected command", cmdAddr, 0);
        else begin
          e = expQ.pop_front();
          chk(cmdChip == e.chip, "R4", "chip", cmdChip, e.chip);
          chk(cmdAddr == e.addr, "R4", "addr", cmdAddr, e.addr);
          chk(cmdSize == e.size, "R5", "size", cmdSize, e.size);
        end
        if (cmdIdx == errIdx) cmdErr = errCode;
        cmdIdx++;
      end
      if (rspValid) begin
        chk(rspMisalign == expMis, "R2", "misalign flag", rspMisalign, expMis);
        chk(rspErr == expErr, "R7", "error code", rspErr, expErr);
        if (expLat >= 0) chk(cyc - startCyc == expLat, "R8", "response latency", cyc - startCyc, expLat);
        rspSeen = 1;
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    curReq = "reset";
    chk(reqReady == 1 && cmdValid == 0 && rspValid == 0, "R1", "reset outputs",
        {reqReady, cmdValid, rspValid}, 3'b100);
    rstN = 1;
    run("R10 two 4K blocks", 32'h1000, 32'h2000, -1, 0, 0);
    run("R5 region crossing", 32'h3000, 32'h5000, -1, 0, 0);
    run("R2 start misaligned", 32'h0800, 32'h1000, -1, 0, 0);
    run("R3 end misaligned", 32'h4000, 32'h2000, -1, 0, 0);
    run("R3 end in 64K region", 32'h8000, 32'hA000, -1, 0, 0);
    run("R8 zero length", 32'h8000, 32'h0, -1, 0, 0);
    run("R6 wrap with region change, stalls", 32'h10000, 32'h30000, -1, 0, 1);
    run("R6 early end on chip count", 32'h50000, 32'h20000, -1, 0, 0);
    run("R7 error on last command", 32'h0, 32'h2000, 1, 4'h5, 0);
    run("R7 error on first command", 32'h4000, 32'hC000, 0, 4'hA, 1);
    cfgRegCount = 3'd2;
    run("R4 lookup limited to region count", 32'h14000, 32'h4000, -1, 0, 0);
    cfgRegCount = 3'd4;
    run("R2 same range rejected with four regions", 32'h14000, 32'h4000, -1, 0, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule